// File: doc/BRIEF.md
# DMA Channel Status Tracker

This block keeps the live status of a single DMA channel serving a USB device endpoint. It presents that status as one 32-bit read-only word. The word carries the number of bytes still owed to the current buffer, an enabled flag, an active flag and three event flags. The event flags stay set until software reads the word. The descriptor fetch engine, the channel arbiter and the data path drive the block with single-cycle pulses: a load of a new descriptor with its byte count, an enable request, a strobe for each data access, the end of a USB transfer, a zero-length packet cancelled by auto-switching, and the arbiter's selection of this channel.

The enabled flag appears one cycle later than the other flags. It clears when the buffer count runs out or when the USB side ends the transfer. The active flag follows the arbiter's selection. If the buffer ran dry while the channel was selected, the active flag also bridges the gap into the next descriptor load. A read of the word clears the three event flags. An event that coincides with the read still leaves its flag set.

Top module: `dma_chan_status`

## Requirements
- R1: The status word holds the remaining byte count in bits 31:16. Bit 6 is descriptor-loaded, bit 5 is end-of-buffer, bit 4 is end-of-transfer, bit 1 is active and bit 0 is enabled. Bits 15:7 and 3:2 read zero. After reset the whole word is zero.
- R2: A descriptor load copies its byte count into the count field at the next edge. Otherwise each access strobe lowers the count by one.
- R3: An access strobe while the count is zero leaves the count at zero.
- R4: An enable request or a descriptor load sets the enabled flag at the second clock edge after the pulse. The flag is still low after the first edge.
- R5: The enabled flag clears at the next edge when an access strobe brings the count from one to zero, or when the USB transfer ends. The exception is a pending enable from the previous cycle, which takes precedence.
- R6: The descriptor-loaded flag sets at the edge after a descriptor load and clears at the edge after a status read.
- R7: The end-of-buffer flag sets at the edge after the count reaches zero through an access strobe, and clears at the edge after a status read.
- R8: The end-of-transfer flag sets on the end of a USB transfer only while the enabled flag and the buffer-close enable are both high. With buffer-close enable low, the end of a USB transfer leaves the flag unchanged. A status read clears the flag.
- R9: A zero-length packet cancelled by auto-switch sets the end-of-transfer flag whatever the enabled flag holds.
- R10: The active flag copies the arbiter selection one edge later. If the count ran out while the channel was selected and the transfer had not ended, the flag stays high until one edge after the next descriptor load or USB transfer end.
- R11: When a flag-setting event and a status read fall in the same cycle, the flag is set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_req | input | 1 | One-cycle enable request pulse |
| desc_load | input | 1 | One-cycle descriptor-loaded pulse |
| desc_count | input | 16 | Byte count of the descriptor being loaded |
| access_stb | input | 1 | One data access made by the channel |
| usb_xfer_end | input | 1 | USB side closed the transfer |
| close_en | input | 1 | Buffer-close enable from the channel control |
| zlp_auto | input | 1 | Zero-length packet cancelled under auto-switch |
| arb_sel | input | 1 | Channel is the selected highest-priority requester |
| rd_stb | input | 1 | Bus read of the status word this cycle |
| status_word | output | 32 | Packed status word |

## Verification
The main collision is between a status read and an event that sets a sticky flag in the same cycle. A read must clear what was visible and must not swallow the new event. The bench provokes this twice. It reads while a zero-length-packet event arrives, and it reads while a descriptor load arrives. It then checks that the flag is still set after the edge and clears on a following read with no event. A second coincidence is between the end of a USB transfer and a pending enable from the cycle before. A cycle-by-cycle reference model settles which of the two wins, and the model is compared with every field on every clock.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    localparam int unsigned POS_EN  = 0;
    localparam int unsigned POS_ACT = 1;
    localparam int unsigned POS_EOT = 4;
    localparam int unsigned POS_EOB = 5;
    localparam int unsigned POS_DL  = 6;
    localparam int unsigned CNT_LSB = 16;

    localparam int unsigned N_STICKY = 3;
    localparam int unsigned SK_EOT   = 0;
    localparam int unsigned SK_EOB   = 1;
    localparam int unsigned SK_DL    = 2;

    typedef struct packed {
        logic pend;
        logic en;
        logic hold;
        logic act;
    } flag_state_t;
endpackage

// File: rtl/dcs_counter.sv
module dcs_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             acc,
    output logic [CNT_W-1:0] cnt,
    output logic             zero_hit
);
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] NONE = '0;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             hit_d;

    always_comb begin
        cnt_d = cnt_q;
        hit_d = 1'b0;
        if (load) begin
            cnt_d = load_val;
        end else if (acc && (cnt_q != NONE)) begin
            cnt_d = cnt_q - ONE;
            hit_d = (cnt_q == ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt      = cnt_q;
    assign zero_hit = hit_d;
endmodule

// File: rtl/dcs_sticky.sv
module dcs_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic rd_clr,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (rd_clr) flag_d = 1'b0;
        if (set_ev) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/dcs_flags.sv
module dcs_flags
    import dcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable_req,
    input  logic desc_load,
    input  logic buf_end,
    input  logic xfer_end,
    input  logic arb_sel,
    output logic enabled,
    output logic active,
    output logic en_pend
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = enable_req | desc_load;
        if (st_q.pend)
            st_d.en = 1'b1;
        else if (buf_end | xfer_end)
            st_d.en = 1'b0;

        if (buf_end && arb_sel && !xfer_end)
            st_d.hold = 1'b1;
        else if (desc_load || xfer_end)
            st_d.hold = 1'b0;

        st_d.act = arb_sel | st_q.hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enabled = st_q.en;
    assign active  = st_q.act;
    assign en_pend = st_q.pend;
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
    import dcs_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_req,
    input  logic             desc_load,
    input  logic [CNT_W-1:0] desc_count,
    input  logic             access_stb,
    input  logic             usb_xfer_end,
    input  logic             close_en,
    input  logic             zlp_auto,
    input  logic             arb_sel,
    input  logic             rd_stb,
    output logic [CNT_LSB+CNT_W-1:0] status_word
);
    localparam int unsigned WORD_W = CNT_LSB + CNT_W;

    logic [CNT_W-1:0]    cnt;
    logic                zero_hit;
    logic                enabled;
    logic                active;
    logic                en_pend;
    logic [N_STICKY-1:0] set_vec;
    logic [N_STICKY-1:0] sticky;

    dcs_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (desc_load),
        .load_val (desc_count),
        .acc      (access_stb),
        .cnt      (cnt),
        .zero_hit (zero_hit)
    );

    dcs_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_req (enable_req),
        .desc_load  (desc_load),
        .buf_end    (zero_hit),
        .xfer_end   (usb_xfer_end),
        .arb_sel    (arb_sel),
        .enabled    (enabled),
        .active     (active),
        .en_pend    (en_pend)
    );

    always_comb begin
        set_vec         = '0;
        set_vec[SK_EOT] = (usb_xfer_end && close_en && enabled) || zlp_auto;
        set_vec[SK_EOB] = zero_hit;
        set_vec[SK_DL]  = desc_load;
    end

    for (genvar gi = 0; gi < N_STICKY; gi++) begin : g_sticky
        dcs_sticky u_sk (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_ev (set_vec[gi]),
            .rd_clr (rd_stb),
            .flag   (sticky[gi])
        );
    end

    always_comb begin
        status_word                       = '0;
        status_word[WORD_W-1:CNT_LSB]     = cnt;
        status_word[POS_DL]               = sticky[SK_DL];
        status_word[POS_EOB]              = sticky[SK_EOB];
        status_word[POS_EOT]              = sticky[SK_EOT];
        status_word[POS_ACT]              = active;
        status_word[POS_EN]               = enabled;
    end
endmodule

// File: rtl/dcs_status_chk.sv
module dcs_status_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable_req,
    input logic             desc_load,
    input logic [CNT_W-1:0] desc_count,
    input logic             access_stb,
    input logic             usb_xfer_end,
    input logic             close_en,
    input logic             zlp_auto,
    input logic             rd_stb,
    input logic             en_pend,
    input logic [16+CNT_W-1:0] status_word
);
    logic [CNT_W-1:0] c;
    assign c = status_word[16+CNT_W-1:16];

    a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (access_stb && !desc_load && c != '0) |=> (c == $past(c) - 1'b1));
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        desc_load |=> (c == $past(desc_count)));
    a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (c == '0 && !desc_load) |=> (c == '0));
    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_req || desc_load) |-> ##2 status_word[0]);
    a_r5_usb_end: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_xfer_end && !en_pend) |=> !status_word[0]);
    a_r6_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        desc_load |=> status_word[6]);
    a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_word[4] && !zlp_auto && !(usb_xfer_end && close_en)) |=> !status_word[4]);
    a_r9_zlp: assert property (@(posedge clk) disable iff (!rst_n)
        zlp_auto |=> status_word[4]);
    a_r11_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !desc_load) |=> !status_word[6]);
endmodule

bind dma_chan_status dcs_status_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_req   (enable_req),
    .desc_load    (desc_load),
    .desc_count   (desc_count),
    .access_stb   (access_stb),
    .usb_xfer_end (usb_xfer_end),
    .close_en     (close_en),
    .zlp_auto     (zlp_auto),
    .rd_stb       (rd_stb),
    .en_pend      (en_pend),
    .status_word  (status_word)
);

// File: tb/test_dma_chan_status.sv
`timescale 1ns/1ps
module test_dma_chan_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_req = 0, desc_load = 0, access_stb = 0;
    logic        usb_xfer_end = 0, close_en = 0, zlp_auto = 0;
    logic        arb_sel = 0, rd_stb = 0;
    logic [15:0] desc_count = '0;
    logic [31:0] status_word;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dma_chan_status i_dma_chan_status (
        .clk(clk), .rst_n(rst_n), .enable_req(enable_req), .desc_load(desc_load),
        .desc_count(desc_count), .access_stb(access_stb), .usb_xfer_end(usb_xfer_end),
        .close_en(close_en), .zlp_auto(zlp_auto), .arb_sel(arb_sel), .rd_stb(rd_stb),
        .status_word(status_word)
    );

    // behavioural reference model
    int m_cnt = 0;
    bit m_pend = 0, m_en = 0, m_dl = 0, m_eob = 0, m_eot = 0, m_hold = 0, m_act = 0;

    always @(posedge clk) begin
        bit eob_ev, eot_ev;
        if (!rst_n) begin
            m_cnt = 0; m_pend = 0; m_en = 0; m_dl = 0;
            m_eob = 0; m_eot = 0; m_hold = 0; m_act = 0;
        end else begin
            eob_ev = access_stb && !desc_load && (m_cnt == 1);
            eot_ev = (usb_xfer_end && close_en && m_en) || zlp_auto;
            m_act  = arb_sel || m_hold;
            if (eob_ev && arb_sel && !usb_xfer_end) m_hold = 1;
            else if (desc_load || usb_xfer_end)     m_hold = 0;
            if (m_pend) m_en = 1;
            else if (eob_ev || usb_xfer_end) m_en = 0;
            m_pend = enable_req || desc_load;
            m_dl   = desc_load || (m_dl && !rd_stb);
            m_eob  = eob_ev    || (m_eob && !rd_stb);
            m_eot  = eot_ev    || (m_eot && !rd_stb);
            if (desc_load) m_cnt = desc_count;
            else if (access_stb && m_cnt > 0) m_cnt = m_cnt - 1;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 model count", status_word[31:16], m_cnt);
            chk("R4 model enabled", status_word[0], m_en);
            chk("R10 model active", status_word[1], m_act);
            chk("R6 model loaded", status_word[6], m_dl);
            chk("R7 model end-of-buffer", status_word[5], m_eob);
            chk("R8 model end-of-transfer", status_word[4], m_eot);
            chk("R1 model reserved", {status_word[15:7], status_word[3:2]}, 0);
        end
    end

    task automatic tick();
        @(negedge clk);
        enable_req = 0; desc_load = 0; access_stb = 0;
        usb_xfer_end = 0; zlp_auto = 0; rd_stb = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset word", status_word, 0);
        rst_n = 1;
        @(negedge clk);

        enable_req = 1; tick();
        chk("R4 not yet enabled", status_word[0], 0);
        tick();
        chk("R4 enabled after latency", status_word[0], 1);

        usb_xfer_end = 1; close_en = 0; tick();
        chk("R5 enabled cleared by usb end", status_word[0], 0);
        chk("R8 no end-of-transfer with close disabled", status_word[4], 0);

        arb_sel = 1; desc_load = 1; desc_count = 16'd3; tick();
        chk("R6 loaded flag set", status_word[6], 1);
        chk("R2 count loaded", status_word[31:16], 3);
        tick();
        chk("R4 enabled after load", status_word[0], 1);
        access_stb = 1; tick();
        chk("R2 count 2", status_word[31:16], 2);
        access_stb = 1; tick();
        chk("R2 count 1", status_word[31:16], 1);
        access_stb = 1; tick();
        chk("R2 count 0", status_word[31:16], 0);
        chk("R7 end-of-buffer set", status_word[5], 1);
        chk("R5 enabled cleared at zero", status_word[0], 0);
        arb_sel = 0; tick();
        chk("R10 active held after exhaustion", status_word[1], 1);
        access_stb = 1; tick();
        chk("R3 count floor", status_word[31:16], 0);
        rd_stb = 1;
        #1 chk("R6 read sees loaded", status_word[6], 1);
        tick();
        chk("R6 cleared on read", status_word[6], 0);
        chk("R7 cleared on read", status_word[5], 0);
        chk("R10 still held before load", status_word[1], 1);

        desc_load = 1; desc_count = 16'd2; tick();
        chk("R10 active through load edge", status_word[1], 1);
        tick();
        chk("R10 active released", status_word[1], 0);
        chk("R4 enabled after second load", status_word[0], 1);

        close_en = 1; usb_xfer_end = 1; tick();
        chk("R8 end-of-transfer set", status_word[4], 1);
        chk("R5 enabled cleared", status_word[0], 0);
        rd_stb = 1; zlp_auto = 1; tick();
        chk("R11 event wins over read", status_word[4], 1);
        rd_stb = 1; tick();
        chk("R8 end-of-transfer cleared on read", status_word[4], 0);
        close_en = 1; usb_xfer_end = 1; tick();
        chk("R8 no set while disabled", status_word[4], 0);
        zlp_auto = 1; tick();
        chk("R9 zero-length sets while disabled", status_word[4], 1);
        rd_stb = 1; desc_load = 1; desc_count = 16'd5; tick();
        chk("R11 load wins over read", status_word[6], 1);
        chk("R11 other flag cleared", status_word[4], 0);

        enable_req = 1; tick();
        usb_xfer_end = 1; tick();
        chk("R5 pending enable beats usb end", status_word[0], 1);
        repeat (3) tick();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule